// File: doc/BRIEF.md
# Write-Enable and Status Controller for a Serial Memory

This block keeps the write permission state of a serial memory device. It holds a write-enable flag, a busy flag that covers the internal programming time, and three stored status bits: a protect-enable bit and two block-protect bits. It does not handle the serial pins. A serial front end sends it events: a frame opened, a frame closed, a complete 8-bit opcode, and each bit that arrives after the opcode. From these events the block decides whether a memory write or a status write may go ahead, when it is committed, and whether an array read is allowed.

The front end asks for the status byte with a status-read command. That command is answered even while a write cycle runs. Every other command that arrives during a write cycle is dropped. A countdown of `WRITE_CYCLES` clock cycles stands in for the programming time. When it runs out, the busy flag and the write-enable flag both clear.

Top module: `wel_status_ctrl`

## Requirements
- R1: After reset, `status_byte` is 8'h00, and `wel` and `wip` are low.
- R2: Opcode 8'h06 (write enable) sets `wel` when the frame closes, provided no bit followed the opcode. `status_byte[1]` mirrors `wel`.
- R3: A write-enable frame that carries one or more bits after the opcode leaves `wel` clear.
- R4: Opcode 8'h04 (write disable), accepted while idle, clears `wel` one cycle after the opcode event.
- R5: Opcode 8'h02 (memory write) pulses `wr_grant` one cycle after the opcode event only if `wel` was set at that time. Otherwise the frame commits nothing.
- R6: A granted memory-write frame commits only if it closes on a byte boundary after at least 2 address bytes and 1 data byte. At that edge `wr_commit` pulses and `wip` rises. `wip` then stays high for exactly `WRITE_CYCLES` cycles, and `wel` clears together with `wip`. A frame that closes off a byte boundary commits nothing and leaves `wel` set.
- R7: Opcode 8'h01 (status write), when `wel` is set, commits at a byte-aligned frame close after at least one data byte. It copies bits 7, 3 and 2 of the first data byte into the stored bits, then runs a write cycle as in R6. Without `wel` the stored bits do not change.
- R8: Opcode 8'h05 (status read) pulses `sr_grant` even while `wip` is high. The status byte layout is bit 7 protect-enable, bits 3:2 block-protect, bit 1 `wel`, bit 0 `wip`; bits 6:4 read 0.
- R9: Opcode 8'h03 (array read) pulses `rd_grant` when idle. While `wip` is high it pulses `rd_refuse` instead.
- R10: Opcodes other than 8'h05 that arrive while `wip` is high have no effect. A write-disable sent during a write cycle leaves `wel` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Pulse: chip select went active |
| frm_end | input | 1 | Pulse: chip select went inactive |
| op_valid | input | 1 | Pulse: eight opcode bits received |
| op_code | input | 8 | Opcode value, valid with `op_valid` |
| bit_tick | input | 1 | Pulse: one serial bit received after the opcode |
| bit_val | input | 1 | Value of that bit, MSB first |
| status_byte | output | 8 | Status byte for the status-read response |
| wel | output | 1 | Write-enable flag |
| wip | output | 1 | Write cycle in progress |
| wr_grant | output | 1 | Pulse: memory write accepted |
| wr_commit | output | 1 | Pulse: memory write committed to the array |
| rd_grant | output | 1 | Pulse: array read accepted |
| rd_refuse | output | 1 | Pulse: array read refused because busy |
| sr_grant | output | 1 | Pulse: status read accepted |

## Verification
A wrong write-enable value shows in `status_byte[1]` on the cycle after the event that caused it. It shows again one cycle after the next write opcode, as a missing or unexpected `wr_grant`. A wrong busy count shows as `wip` falling early or late against the `WRITE_CYCLES` count, with `wel` falling on the same edge. A busy flag left stuck shows on the very next read opcode as `rd_refuse` where `rd_grant` was due. Mistakes in the frame tracking, such as a wrong bit phase or byte count, show at frame close as a missing or extra `wr_commit` or status-bit load.

// File: rtl/wsc_pkg.sv
`timescale 1ns/1ps
package wsc_pkg;
   localparam int OP_W = 8;

   localparam logic [OP_W-1:0] OPC_WRSR  = 8'h01;
   localparam logic [OP_W-1:0] OPC_WRITE = 8'h02;
   localparam logic [OP_W-1:0] OPC_READ  = 8'h03;
   localparam logic [OP_W-1:0] OPC_WRDI  = 8'h04;
   localparam logic [OP_W-1:0] OPC_RDSR  = 8'h05;
   localparam logic [OP_W-1:0] OPC_WREN  = 8'h06;

   // status byte bit positions
   localparam int SB_WIP  = 0;
   localparam int SB_WEL  = 1;
   localparam int SB_BPL  = 2;
   localparam int SB_BPH  = 3;
   localparam int SB_WPEN = 7;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_WREN,
      CMD_WRDI,
      CMD_WRITE,
      CMD_WRSR,
      CMD_RDSR,
      CMD_READ
   } cmd_t;

   function automatic cmd_t decode_op(input logic [OP_W-1:0] op);
      cmd_t c;
      case (op)
         OPC_WREN:  c = CMD_WREN;
         OPC_WRDI:  c = CMD_WRDI;
         OPC_WRITE: c = CMD_WRITE;
         OPC_WRSR:  c = CMD_WRSR;
         OPC_RDSR:  c = CMD_RDSR;
         OPC_READ:  c = CMD_READ;
         default:   c = CMD_NONE;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/wsc_frame_track.sv
`timescale 1ns/1ps
module wsc_frame_track
   import wsc_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_BYTES = 2,
   localparam int BCNT_MAX  = ADDR_BYTES + 1,
   localparam int BCNT_W    = $clog2(BCNT_MAX + 1),
   localparam int PH_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_start,
   input  logic              frm_end,
   input  logic              op_load,
   input  cmd_t              op_cmd,
   input  logic              bit_tick,
   input  logic              bit_val,
   output cmd_t              sess_cmd,
   output logic              aligned,
   output logic [BCNT_W-1:0] byte_cnt,
   output logic              bits_seen,
   output logic [DATA_W-1:0] first_byte
);
   logic [PH_W-1:0]   phase_q;
   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] shift_nx;
   logic              byte_last;

   assign shift_nx  = {shift_q[DATA_W-2:0], bit_val};
   assign byte_last = (phase_q == PH_W'(DATA_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || frm_start || frm_end) begin
         sess_cmd   <= CMD_NONE;
         phase_q    <= '0;
         byte_cnt   <= '0;
         bits_seen  <= 1'b0;
         shift_q    <= '0;
         first_byte <= '0;
      end else if (op_load) begin
         sess_cmd  <= op_cmd;
         phase_q   <= '0;
         byte_cnt  <= '0;
         bits_seen <= 1'b0;
      end else if (bit_tick && sess_cmd != CMD_NONE) begin
         bits_seen <= 1'b1;
         shift_q   <= shift_nx;
         phase_q   <= byte_last ? '0 : phase_q + 1'b1;
         if (byte_last) begin
            if (byte_cnt == '0)
               first_byte <= shift_nx;
            if (byte_cnt != BCNT_W'(BCNT_MAX))
               byte_cnt <= byte_cnt + 1'b1;
         end
      end
   end

   assign aligned = (phase_q == '0);
endmodule

// File: rtl/wsc_wel_latch.sv
`timescale 1ns/1ps
module wsc_wel_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic wel_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         wel_o <= 1'b0;
      else if (clr_i)
         wel_o <= 1'b0;
      else if (set_i)
         wel_o <= 1'b1;
   end
endmodule

// File: rtl/wsc_busy_timer.sv
`timescale 1ns/1ps
module wsc_busy_timer #(
   parameter int CYCLES = 16,
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   generate
      if (CYCLES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)
               busy_o <= 1'b0;
            else if (start_i)
               busy_o <= 1'b1;
            else
               busy_o <= 1'b0;
         end
         assign done_o = busy_o;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy_o <= 1'b0;
               cnt_q  <= '0;
            end else if (start_i) begin
               busy_o <= 1'b1;
               cnt_q  <= CNT_W'(CYCLES - 1);
            end else if (busy_o) begin
               if (cnt_q == '0)
                  busy_o <= 1'b0;
               else
                  cnt_q <= cnt_q - 1'b1;
            end
         end
         assign done_o = busy_o && (cnt_q == '0) && !start_i;
      end
   endgenerate
endmodule

// File: rtl/wsc_status_reg.sv
`timescale 1ns/1ps
module wsc_status_reg
   import wsc_pkg::*;
#(
   parameter int  DATA_W   = 8,
   parameter bit  HAS_WPEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              wel_i,
   input  logic              wip_i,
   output logic [DATA_W-1:0] sr_o
);
   logic [1:0] bp_q;
   logic       wpen_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         bp_q <= 2'b00;
      else if (load_i)
         bp_q <= {din_i[SB_BPH], din_i[SB_BPL]};
   end

   generate
      if (HAS_WPEN) begin : g_wpen
         always_ff @(posedge clk) begin
            if (!rst_n)
               wpen_q <= 1'b0;
            else if (load_i)
               wpen_q <= din_i[SB_WPEN];
         end
      end else begin : g_no_wpen
         assign wpen_q = 1'b0;
      end
   endgenerate

   always_comb begin
      sr_o          = '0;
      sr_o[SB_WPEN] = wpen_q;
      sr_o[SB_BPH]  = bp_q[1];
      sr_o[SB_BPL]  = bp_q[0];
      sr_o[SB_WEL]  = wel_i;
      sr_o[SB_WIP]  = wip_i;
   end
endmodule

// File: rtl/wel_status_ctrl.sv
`timescale 1ns/1ps
module wel_status_ctrl
   import wsc_pkg::*;
#(
   parameter int WRITE_CYCLES = 10000,
   parameter int ADDR_BYTES   = 2,
   parameter bit HAS_WPEN     = 1'b1,
   localparam int DATA_W      = 8,
   localparam int BCNT_W      = $clog2(ADDR_BYTES + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_start,
   input  logic              frm_end,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_code,
   input  logic              bit_tick,
   input  logic              bit_val,
   output logic [DATA_W-1:0] status_byte,
   output logic              wel,
   output logic              wip,
   output logic              wr_grant,
   output logic              wr_commit,
   output logic              rd_grant,
   output logic              rd_refuse,
   output logic              sr_grant
);
   generate
      if (WRITE_CYCLES < 1) begin : g_bad_cycles
         $error("WRITE_CYCLES must be at least 1");
      end
      if (ADDR_BYTES < 1) begin : g_bad_addr
         $error("ADDR_BYTES must be at least 1");
      end
   endgenerate

   cmd_t              cmd_now;
   cmd_t              cmd_eff;
   cmd_t              sess_cmd;
   logic              accept;
   logic              aligned;
   logic [BCNT_W-1:0] byte_cnt;
   logic              bits_seen;
   logic [DATA_W-1:0] first_byte;
   logic              wren_fire, wrdi_fire, write_fire, wrsr_fire;
   logic              cyc_done;

   assign cmd_now = decode_op(op_code);
   assign accept  = op_valid && (!wip || cmd_now == CMD_RDSR);

   always_comb begin
      cmd_eff = CMD_NONE;
      if (accept) begin
         if ((cmd_now == CMD_WRITE || cmd_now == CMD_WRSR) && !wel)
            cmd_eff = CMD_NONE;
         else
            cmd_eff = cmd_now;
      end
   end

   wsc_frame_track #(
      .DATA_W     (DATA_W),
      .ADDR_BYTES (ADDR_BYTES)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_start  (frm_start),
      .frm_end    (frm_end),
      .op_load    (op_valid),
      .op_cmd     (cmd_eff),
      .bit_tick   (bit_tick),
      .bit_val    (bit_val),
      .sess_cmd   (sess_cmd),
      .aligned    (aligned),
      .byte_cnt   (byte_cnt),
      .bits_seen  (bits_seen),
      .first_byte (first_byte)
   );

   assign wren_fire  = frm_end && sess_cmd == CMD_WREN && !bits_seen;
   assign wrdi_fire  = accept && cmd_now == CMD_WRDI;
   assign write_fire = frm_end && sess_cmd == CMD_WRITE && aligned
                       && byte_cnt >= BCNT_W'(ADDR_BYTES + 1);
   assign wrsr_fire  = frm_end && sess_cmd == CMD_WRSR && aligned
                       && byte_cnt != '0;

   wsc_busy_timer #(
      .CYCLES (WRITE_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (write_fire || wrsr_fire),
      .busy_o  (wip),
      .done_o  (cyc_done)
   );

   wsc_wel_latch u_wel (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wren_fire),
      .clr_i (wrdi_fire || cyc_done),
      .wel_o (wel)
   );

   wsc_status_reg #(
      .DATA_W   (DATA_W),
      .HAS_WPEN (HAS_WPEN)
   ) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (wrsr_fire),
      .din_i  (first_byte),
      .wel_i  (wel),
      .wip_i  (wip),
      .sr_o   (status_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_grant  <= 1'b0;
         wr_commit <= 1'b0;
         rd_grant  <= 1'b0;
         rd_refuse <= 1'b0;
         sr_grant  <= 1'b0;
      end else begin
         wr_grant  <= cmd_eff == CMD_WRITE;
         wr_commit <= write_fire;
         rd_grant  <= cmd_eff == CMD_READ;
         rd_refuse <= op_valid && cmd_now == CMD_READ && wip;
         sr_grant  <= cmd_eff == CMD_RDSR;
      end
   end
endmodule

// File: rtl/wel_status_ctrl_chk.sv
`timescale 1ns/1ps
module wel_status_ctrl_chk
   import wsc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       frm_end,
   input logic       op_valid,
   input logic [7:0] op_code,
   input logic [7:0] status_byte,
   input logic       wel,
   input logic       wip,
   input logic       wr_grant,
   input logic       wr_commit,
   input logic       rd_grant
);
   AST_WEL_SET_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(frm_end)); // R2

   AST_WEL_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wel) |-> ($fell(wip) || $past(op_valid && op_code == OPC_WRDI))); // R4

   AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |-> wel); // R5

   AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> (wip && $past(frm_end))); // R6

   AST_WIP_RISE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(frm_end)); // R6

   AST_STATUS_BITS_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_byte[7:2]) |-> $past(frm_end)); // R7

   AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant |-> !$past(wip)); // R9

   AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |-> !$past(wip)); // R10
endmodule

bind wel_status_ctrl wel_status_ctrl_chk u_chk (.*);

// File: tb/wel_status_ctrl_bench.sv
`timescale 1ns/1ps
module wel_status_ctrl_bench;
   localparam int CYC = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_start = 1'b0, frm_end = 1'b0, op_valid = 1'b0;
   logic [7:0] op_code = 8'h00;
   logic       bit_tick = 1'b0, bit_val = 1'b0;
   logic [7:0] status_byte;
   logic       wel, wip, wr_grant, wr_commit, rd_grant, rd_refuse, sr_grant;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   wel_status_ctrl #(.WRITE_CYCLES(CYC)) u_wel_status_ctrl (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
      .op_valid(op_valid), .op_code(op_code), .bit_tick(bit_tick),
      .bit_val(bit_val), .status_byte(status_byte), .wel(wel), .wip(wip),
      .wr_grant(wr_grant), .wr_commit(wr_commit), .rd_grant(rd_grant),
      .rd_refuse(rd_refuse), .sr_grant(sr_grant)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic open_frame();
      frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
   endtask

   task automatic send_op(input logic [7:0] b);
      op_valid = 1'b1; op_code = b; @(negedge clk); op_valid = 1'b0;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         bit_tick = 1'b1; bit_val = b[i]; @(negedge clk);
      end
      bit_tick = 1'b0;
   endtask

   task automatic close_frame();
      frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4 * CYC && wip; i++) @(negedge clk);
   endtask

   task automatic do_wren();
      open_frame(); send_op(8'h06); close_frame();
   endtask

   task automatic t_reset();
      chk("R1 status", status_byte, 8'h00);
      chk("R1 wel", {7'd0, wel}, 8'h00);
      chk("R1 wip", {7'd0, wip}, 8'h00);
   endtask

   task automatic t_wren_wrdi();
      do_wren();
      chk("R2 status after wren", status_byte, 8'h02);
      open_frame(); send_op(8'h04);
      chk("R4 wel after wrdi", {7'd0, wel}, 8'h00);
      close_frame();
      open_frame(); send_op(8'h06); send_bits(8'h80, 1); close_frame();
      chk("R3 wel after long wren", {7'd0, wel}, 8'h00);
   endtask

   task automatic t_write_no_wel();
      open_frame(); send_op(8'h02);
      chk("R5 grant without wel", {7'd0, wr_grant}, 8'h00);
      send_bits(8'h00, 8); send_bits(8'h10, 8); send_bits(8'hA5, 8);
      close_frame();
      chk("R5 commit without wel", {6'd0, wr_commit, wip}, 8'h00);
   endtask

   task automatic t_write_misaligned();
      do_wren();
      open_frame(); send_op(8'h02);
      chk("R5 grant with wel", {7'd0, wr_grant}, 8'h01);
      send_bits(8'h00, 8); send_bits(8'h20, 8); send_bits(8'hFF, 5);
      close_frame();
      chk("R6 misaligned no commit", {6'd0, wr_commit, wip}, 8'h00);
      chk("R6 misaligned keeps wel", {7'd0, wel}, 8'h01);
   endtask

   task automatic t_write_timing();
      int n;
      open_frame(); send_op(8'h02);
      send_bits(8'h00, 8); send_bits(8'h30, 8); send_bits(8'h5A, 8);
      close_frame();
      chk("R6 commit pulse", {7'd0, wr_commit}, 8'h01);
      n = 0;
      while (wip && n < 4 * CYC) begin n++; @(negedge clk); end
      chk("R6 busy length", 8'(n), 8'(CYC));
      chk("R6 wel cleared at end", {7'd0, wel}, 8'h00);
   endtask

   task automatic t_busy_commands();
      do_wren();
      open_frame(); send_op(8'h02);
      send_bits(8'h00, 8); send_bits(8'h40, 8); send_bits(8'h11, 8);
      close_frame();
      open_frame(); send_op(8'h05);
      chk("R8 status read while busy", {7'd0, sr_grant}, 8'h01);
      chk("R8 status busy value", status_byte, 8'h03);
      close_frame();
      open_frame(); send_op(8'h03);
      chk("R9 read refused busy", {6'd0, rd_grant, rd_refuse}, 8'h01);
      close_frame();
      open_frame(); send_op(8'h04); close_frame();
      chk("R10 wrdi ignored busy", {7'd0, wel}, 8'h01);
      open_frame(); send_op(8'h02);
      chk("R10 write ignored busy", {7'd0, wr_grant}, 8'h00);
      close_frame();
      wait_idle();
      open_frame(); send_op(8'h03);
      chk("R9 read granted idle", {6'd0, rd_grant, rd_refuse}, 8'h02);
      close_frame();
   endtask

   task automatic t_status_write();
      do_wren();
      open_frame(); send_op(8'h01); send_bits(8'hFF, 8); close_frame();
      chk("R7 R8 status during wrsr", status_byte, 8'h8F);
      wait_idle();
      chk("R7 status after wrsr", status_byte, 8'h8C);
      open_frame(); send_op(8'h01); send_bits(8'h00, 8); close_frame();
      chk("R7 wrsr without wel", {status_byte[7:1], wip}, 8'h8C);
      do_wren();
      open_frame(); send_op(8'h01); send_bits(8'h04, 8); close_frame();
      wait_idle();
      chk("R7 bp0 only", status_byte, 8'h04);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wren_wrdi();
      t_write_no_wel();
      t_write_misaligned();
      t_write_timing();
      t_busy_commands();
      t_status_write();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule